// File: doc/BRIEF.md
# Double-Buffered Per-Channel Gamma Lookup Table

This block applies gamma correction to a stream of RGB pixels by direct table lookup. Each colour component of an incoming pixel selects an entry in that channel's table, and the entry is sent out one cycle later. The block holds two complete table banks. The pixel path reads whichever bank is active, and a host register port fills the other one. Once a new curve is loaded, the host programs a bank change. The change is applied at the next frame-start strobe, so the curve never switches partway through a frame. A bypass mode sends pixels through unchanged, with the same one-cycle latency.

Loading uses a write index and a data register. The host picks the target bank and a 3-bit channel mask, writes the index register to set the start point, and then streams data words. Each word goes to every enabled channel at the current index, after which the index steps forward by one. A load for one channel is 2^PIX_W segment points plus one closing endpoint entry, so each table has 2^PIX_W+1 entries. The table RAM can be forced into a low-power state. After it is released, a status field reports a wake-up period of WAKE_CYC cycles before it reads ready.

Top module: `dual_bank_gamma_lut`

## Requirements
- R1: After reset, control reads 0 (bypass, bank A), host config reads 7 (mask all channels, target bank A), the index reads 0, status reads 0 (bypass, bank A, powered), and out_valid is low.
- R2: When the active mode field is any value other than 2, each valid pixel appears unchanged on the outputs exactly one cycle later, with out_valid high in that cycle only.
- R3: When the active mode is 2 and the RAM is powered, each output channel one cycle after a valid pixel equals the active bank's entry for that channel, indexed by that channel's input component.
- R4: Control register (address 0) bits [1:0] hold the mode (0 bypass, 2 RAM) and bit 4 holds the bank (0 = A, 1 = B). A write to them changes neither the pixel path nor the status readback until a frame_start strobe. After that strobe, status (address 5) bits [1:0] and bit 4 report the mode and bank in use.
- R5: Host config (address 1) bit 4 selects the bank that data writes go to (0 = A, 1 = B), regardless of the active bank. Writes to the inactive bank do not change pixel output.
- R6: Host config bits [2:0] are the channel write mask: bit 2 red, bit 1 green, bit 0 blue (4, 2, 1 select one channel and 7 selects all three). A data write leaves the entries of unselected channels unchanged.
- R7: A write to the index register (address 2) sets the index, clamped to the last entry 2^PIX_W. Each data write (address 3, bits [PIX_W-1:0]) stores at the current index, and the index then advances by one, saturating at the last entry. The index reads back at address 2.
- R8: A nonzero value written to the power field (address 4, bits [1:0]) powers the RAM down and status bits [9:8] read 3 from the next cycle. Writing 0 makes them read 1 for WAKE_CYC cycles and then 0 (powered).
- R9: While status bits [9:8] are not 0, data writes are dropped and leave the index unchanged, and the pixel path in RAM mode outputs zero on every channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host register write strobe |
| host_waddr | input | 3 | Host write address |
| host_wdata | input | 32 | Host write data |
| host_raddr | input | 3 | Host read address |
| host_rdata | output | 32 | Host read data (combinational) |
| frame_start | input | 1 | Frame-start strobe that applies the pending mode and bank |
| pix_valid | input | 1 | Input pixel valid |
| pix_r | input | PIX_W | Red input component |
| pix_g | input | PIX_W | Green input component |
| pix_b | input | PIX_W | Blue input component |
| out_valid | output | 1 | Output pixel valid |
| out_r | output | PIX_W | Red output component |
| out_g | output | PIX_W | Green output component |
| out_b | output | PIX_W | Blue output component |

## Verification
The bench sweeps every input code through both banks, with a distinct curve for each channel. A design that swaps channels, misreads the mask bit order, or reads the wrong bank produces wrong values on specific codes. It checks that a programmed bank or mode change stays invisible until the frame strobe, which catches a design that switches immediately. It writes past the endpoint entry and writes an out-of-range index, which exposes an index that wraps instead of saturating. It also walks through power-down and wake-up, where a design that keeps accepting data while unpowered shows a moved index, and a design that skips or miscounts the wake period shows the wrong status.

// File: rtl/gam_lut_pkg.sv
package gam_lut_pkg;

    // Number of colour channels; channel 0 is red, 1 green, 2 blue.
    localparam int NCH = 3;

    // Host register addresses.
    localparam logic [2:0] ADR_CTRL   = 3'd0;
    localparam logic [2:0] ADR_HCFG   = 3'd1;
    localparam logic [2:0] ADR_INDEX  = 3'd2;
    localparam logic [2:0] ADR_DATA   = 3'd3;
    localparam logic [2:0] ADR_POWER  = 3'd4;
    localparam logic [2:0] ADR_STATUS = 3'd5;

    localparam logic [1:0] MODE_RAM = 2'd2;

    typedef enum logic [1:0] {
        PWR_READY  = 2'd0,
        PWR_RISING = 2'd1,
        PWR_DOWN   = 2'd3
    } pwr_state_e;

    // Mode and bank as seen by the pixel path.
    typedef struct packed {
        logic [1:0] mode;
        logic       bank;
    } lut_view_t;

    function automatic logic mode_uses_ram(input logic [1:0] m);
        return m == MODE_RAM;
    endfunction

    // Mask bit that enables channel c (red is the most significant bit).
    function automatic int mask_bit(input int c);
        return NCH - 1 - c;
    endfunction

endpackage

// File: rtl/gam_lut_regs.sv
module gam_lut_regs
    import gam_lut_pkg::*;
#(
    parameter int PIX_W    = 6,
    parameter int WAKE_CYC = 8,
    localparam int DEPTH   = (1 << PIX_W) + 1,
    localparam int IDX_W   = PIX_W + 1,
    localparam int WAKE_W  = $clog2(WAKE_CYC + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_we,
    input  logic [2:0]        host_waddr,
    input  logic [31:0]       host_wdata,
    input  logic [2:0]        host_raddr,
    output logic [31:0]       host_rdata,
    input  logic              frame_start,
    output lut_view_t         cur_view,
    output logic              ram_ready,
    output pwr_state_e        pwr_state,
    output logic              wr_fire,
    output logic              wr_bank,
    output logic [NCH-1:0]    wr_mask,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [PIX_W-1:0]  wr_data
);

    localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(DEPTH - 1);
    localparam logic [WAKE_W-1:0] WAKE_END = WAKE_W'(WAKE_CYC - 1);

    lut_view_t         pend_view;
    logic [NCH-1:0]    mask_q;
    logic              hbank_q;
    logic [IDX_W-1:0]  idx_q;
    logic [1:0]        force_q;
    logic [WAKE_W-1:0] wake_cnt;

    logic wr_ctrl, wr_hcfg, wr_index, wr_dat, wr_pwr;

    assign wr_ctrl  = host_we && (host_waddr == ADR_CTRL);
    assign wr_hcfg  = host_we && (host_waddr == ADR_HCFG);
    assign wr_index = host_we && (host_waddr == ADR_INDEX);
    assign wr_dat   = host_we && (host_waddr == ADR_DATA);
    assign wr_pwr   = host_we && (host_waddr == ADR_POWER);

    assign ram_ready = (pwr_state == PWR_READY);

    // Pending and applied view: the pending copy moves over only at frame start.
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_view <= '0;
            cur_view  <= '0;
        end else begin
            if (wr_ctrl) begin
                pend_view.mode <= host_wdata[1:0];
                pend_view.bank <= host_wdata[4];
            end
            if (frame_start) cur_view <= pend_view;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q  <= '1;
            hbank_q <= 1'b0;
        end else if (wr_hcfg) begin
            mask_q  <= host_wdata[NCH-1:0];
            hbank_q <= host_wdata[4];
        end
    end

    // Write index: loads clamped, advances on accepted data, saturates at the end.
    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
        end else if (wr_index) begin
            idx_q <= (host_wdata > 32'(DEPTH - 1)) ? LAST_IDX : host_wdata[IDX_W-1:0];
        end else if (wr_fire && (idx_q != LAST_IDX)) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    // Memory power sequencing.
    always_ff @(posedge clk) begin
        if (rst) begin
            force_q   <= '0;
            pwr_state <= PWR_READY;
            wake_cnt  <= '0;
        end else if (wr_pwr) begin
            force_q <= host_wdata[1:0];
            if (host_wdata[1:0] != 2'd0) begin
                pwr_state <= PWR_DOWN;
            end else if (pwr_state == PWR_DOWN) begin
                pwr_state <= PWR_RISING;
                wake_cnt  <= '0;
            end
        end else if (pwr_state == PWR_RISING) begin
            if (wake_cnt == WAKE_END) pwr_state <= PWR_READY;
            else                      wake_cnt  <= wake_cnt + 1'b1;
        end
    end

    assign wr_fire = wr_dat && ram_ready;
    assign wr_bank = hbank_q;
    assign wr_mask = mask_q;
    assign wr_idx  = idx_q;
    assign wr_data = host_wdata[PIX_W-1:0];

    always_comb begin
        host_rdata = '0;
        case (host_raddr)
            ADR_CTRL: begin
                host_rdata[1:0] = pend_view.mode;
                host_rdata[4]   = pend_view.bank;
            end
            ADR_HCFG: begin
                host_rdata[NCH-1:0] = mask_q;
                host_rdata[4]       = hbank_q;
            end
            ADR_INDEX:  host_rdata[IDX_W-1:0] = idx_q;
            ADR_POWER:  host_rdata[1:0] = force_q;
            ADR_STATUS: begin
                host_rdata[1:0] = cur_view.mode;
                host_rdata[4]   = cur_view.bank;
                host_rdata[9:8] = pwr_state;
            end
            default: host_rdata = '0;
        endcase
    end

    logic unused_wdata;
    assign unused_wdata = ^{host_wdata[31:5], host_wdata[3:2]};

endmodule

// File: rtl/gam_lut_store.sv
module gam_lut_store
    import gam_lut_pkg::*;
#(
    parameter int PIX_W  = 6,
    localparam int DEPTH = (1 << PIX_W) + 1,
    localparam int IDX_W = PIX_W + 1
) (
    input  logic                               clk,
    input  logic                               wr_fire,
    input  logic                               wr_bank,
    input  logic [NCH-1:0]                     wr_mask,
    input  logic [IDX_W-1:0]                   wr_idx,
    input  logic [PIX_W-1:0]                   wr_data,
    input  logic                               rd_en,
    input  logic [NCH-1:0][PIX_W-1:0]          rd_pix,
    output logic [1:0][NCH-1:0][PIX_W-1:0]     bank_q
);

    for (genvar b = 0; b < 2; b++) begin : g_bank
        localparam logic BANK_ID = 1'(b);
        for (genvar c = 0; c < NCH; c++) begin : g_chan
            localparam int MB = NCH - 1 - c;
            logic [PIX_W-1:0] mem [DEPTH];
            logic [PIX_W-1:0] q;

            always_ff @(posedge clk) begin
                if (wr_fire && (wr_bank == BANK_ID) && wr_mask[MB])
                    mem[wr_idx] <= wr_data;
            end

            always_ff @(posedge clk) begin
                if (rd_en) q <= mem[{1'b0, rd_pix[c]}];
            end

            assign bank_q[b][c] = q;
        end
    end

endmodule

// File: rtl/gam_lut_pixel.sv
module gam_lut_pixel
    import gam_lut_pkg::*;
#(
    parameter int PIX_W = 6
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               pix_valid,
    input  logic [NCH-1:0][PIX_W-1:0]          pix_in,
    input  lut_view_t                          cur_view,
    input  logic                               ram_ready,
    input  logic [1:0][NCH-1:0][PIX_W-1:0]     bank_q,
    output logic                               out_valid,
    output logic [NCH-1:0][PIX_W-1:0]          pix_out
);

    logic                       use_ram_q;
    logic                       ready_q;
    logic                       bank_sel_q;
    logic [NCH-1:0][PIX_W-1:0]  thru_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            use_ram_q  <= 1'b0;
            ready_q    <= 1'b0;
            bank_sel_q <= 1'b0;
            thru_q     <= '0;
        end else begin
            out_valid <= pix_valid;
            if (pix_valid) begin
                use_ram_q  <= mode_uses_ram(cur_view.mode);
                ready_q    <= ram_ready;
                bank_sel_q <= cur_view.bank;
                thru_q     <= pix_in;
            end
        end
    end

    always_comb begin
        if (!use_ram_q)    pix_out = thru_q;
        else if (!ready_q) pix_out = '0;
        else               pix_out = bank_q[bank_sel_q];
    end

endmodule

// File: rtl/dual_bank_gamma_lut.sv
module dual_bank_gamma_lut
    import gam_lut_pkg::*;
#(
    parameter int PIX_W    = 6,
    parameter int WAKE_CYC = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_we,
    input  logic [2:0]        host_waddr,
    input  logic [31:0]       host_wdata,
    input  logic [2:0]        host_raddr,
    output logic [31:0]       host_rdata,
    input  logic              frame_start,
    input  logic              pix_valid,
    input  logic [PIX_W-1:0]  pix_r,
    input  logic [PIX_W-1:0]  pix_g,
    input  logic [PIX_W-1:0]  pix_b,
    output logic              out_valid,
    output logic [PIX_W-1:0]  out_r,
    output logic [PIX_W-1:0]  out_g,
    output logic [PIX_W-1:0]  out_b
);

    localparam int IDX_W = PIX_W + 1;

    lut_view_t                          cur_view;
    logic                               ram_ready;
    pwr_state_e                         pwr_state;
    logic                               wr_fire;
    logic                               wr_bank;
    logic [NCH-1:0]                     wr_mask;
    logic [IDX_W-1:0]                   wr_idx;
    logic [PIX_W-1:0]                   wr_data;
    logic [NCH-1:0][PIX_W-1:0]          pix_in;
    logic [NCH-1:0][PIX_W-1:0]          pix_out;
    logic [1:0][NCH-1:0][PIX_W-1:0]     bank_q;

    assign pix_in[0] = pix_r;
    assign pix_in[1] = pix_g;
    assign pix_in[2] = pix_b;

    gam_lut_regs #(.PIX_W(PIX_W), .WAKE_CYC(WAKE_CYC)) regs_i (
        .clk(clk), .rst(rst),
        .host_we(host_we), .host_waddr(host_waddr), .host_wdata(host_wdata),
        .host_raddr(host_raddr), .host_rdata(host_rdata),
        .frame_start(frame_start),
        .cur_view(cur_view), .ram_ready(ram_ready), .pwr_state(pwr_state),
        .wr_fire(wr_fire), .wr_bank(wr_bank), .wr_mask(wr_mask),
        .wr_idx(wr_idx), .wr_data(wr_data)
    );

    gam_lut_store #(.PIX_W(PIX_W)) store_i (
        .clk(clk),
        .wr_fire(wr_fire), .wr_bank(wr_bank), .wr_mask(wr_mask),
        .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_en(pix_valid), .rd_pix(pix_in),
        .bank_q(bank_q)
    );

    gam_lut_pixel #(.PIX_W(PIX_W)) pixel_i (
        .clk(clk), .rst(rst),
        .pix_valid(pix_valid), .pix_in(pix_in),
        .cur_view(cur_view), .ram_ready(ram_ready),
        .bank_q(bank_q),
        .out_valid(out_valid), .pix_out(pix_out)
    );

    assign out_r = pix_out[0];
    assign out_g = pix_out[1];
    assign out_b = pix_out[2];

endmodule

// File: rtl/gam_lut_checker.sv
module gam_lut_checker #(
    parameter int PIX_W  = 6,
    localparam int IDX_W = PIX_W + 1,
    localparam int DEPTH = (1 << PIX_W) + 1
) (
    input logic              clk,
    input logic              rst,
    input logic              host_we,
    input logic [2:0]        host_waddr,
    input logic [31:0]       host_wdata,
    input logic              frame_start,
    input logic              pix_valid,
    input logic [PIX_W-1:0]  pix_r,
    input logic [PIX_W-1:0]  pix_g,
    input logic [PIX_W-1:0]  pix_b,
    input logic              out_valid,
    input logic [PIX_W-1:0]  out_r,
    input logic [PIX_W-1:0]  out_g,
    input logic [PIX_W-1:0]  out_b,
    input logic [1:0]        mode_cur,
    input logic              bank_cur,
    input logic [IDX_W-1:0]  idx,
    input logic [1:0]        pwr_state
);

    logic data_wr, pwr_off_wr;
    assign data_wr    = host_we && (host_waddr == 3'd3);
    assign pwr_off_wr = host_we && (host_waddr == 3'd4) && (host_wdata[1:0] != 2'd0);

    // R2: bypass passes pixels unchanged with one cycle of latency
    p_bypass_thru_r2: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && mode_cur != 2'd2) |=>
            (out_valid && out_r == $past(pix_r) && out_g == $past(pix_g) && out_b == $past(pix_b)));

    // R2: no output without an input one cycle earlier
    p_no_spurious_r2: assert property (@(posedge clk) disable iff (rst)
        !pix_valid |=> !out_valid);

    // R4: the applied mode and bank move only after a frame strobe
    p_bank_at_strobe_r4: assert property (@(posedge clk) disable iff (rst)
        !frame_start |=> ($stable(bank_cur) && $stable(mode_cur)));

    // R7: accepted data advances the index until the last entry
    p_idx_step_r7: assert property (@(posedge clk) disable iff (rst)
        (data_wr && pwr_state == 2'd0 && idx != IDX_W'(DEPTH - 1)) |=> idx == $past(idx) + 1'b1);

    // R7: the index never passes the endpoint entry
    p_idx_bound_r7: assert property (@(posedge clk) disable iff (rst)
        idx <= IDX_W'(DEPTH - 1));

    // R8: a nonzero force powers the RAM down on the next cycle
    p_pwr_down_r8: assert property (@(posedge clk) disable iff (rst)
        pwr_off_wr |=> pwr_state == 2'd3);

    // R9: data writes are dropped while the RAM is not ready
    p_drop_unpowered_r9: assert property (@(posedge clk) disable iff (rst)
        (data_wr && pwr_state != 2'd0) |=> $stable(idx));

    // R9: RAM mode outputs zero while unpowered
    p_zero_unpowered_r9: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && mode_cur == 2'd2 && pwr_state != 2'd0) |=>
            (out_r == '0 && out_g == '0 && out_b == '0));

endmodule

bind dual_bank_gamma_lut gam_lut_checker #(.PIX_W(PIX_W)) chk_i (
    .clk(clk), .rst(rst),
    .host_we(host_we), .host_waddr(host_waddr), .host_wdata(host_wdata),
    .frame_start(frame_start),
    .pix_valid(pix_valid), .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
    .out_valid(out_valid), .out_r(out_r), .out_g(out_g), .out_b(out_b),
    .mode_cur(cur_view.mode), .bank_cur(cur_view.bank),
    .idx(wr_idx), .pwr_state(pwr_state)
);

// File: tb/dual_bank_gamma_lut_tb_top.sv
module dual_bank_gamma_lut_tb_top;

    localparam int PW    = 4;
    localparam int NV    = 1 << PW;
    localparam int DEP   = NV + 1;
    localparam int WAKE  = 4;
    localparam int MSK   = NV - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          host_we = 1'b0;
    logic [2:0]    host_waddr = '0;
    logic [31:0]   host_wdata = '0;
    logic [2:0]    host_raddr = '0;
    logic [31:0]   host_rdata;
    logic          frame_start = 1'b0;
    logic          pix_valid = 1'b0;
    logic [PW-1:0] pix_r = '0, pix_g = '0, pix_b = '0;
    logic          out_valid;
    logic [PW-1:0] out_r, out_g, out_b;

    int vectors = 0;
    int miscompares = 0;

    // Bench model of table contents and host state
    int lut [2][3][DEP];
    int m_bank = 0;
    int m_mask = 7;
    int m_idx  = 0;
    bit m_ready = 1'b1;

    always #10 clk = ~clk;

    dual_bank_gamma_lut #(.PIX_W(PW), .WAKE_CYC(WAKE)) dut_i (
        .clk(clk), .rst(rst),
        .host_we(host_we), .host_waddr(host_waddr), .host_wdata(host_wdata),
        .host_raddr(host_raddr), .host_rdata(host_rdata),
        .frame_start(frame_start),
        .pix_valid(pix_valid), .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
        .out_valid(out_valid), .out_r(out_r), .out_g(out_g), .out_b(out_b)
    );

    task automatic check(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    task automatic wr(input logic [2:0] a, input int d);
        @(negedge clk);
        host_we = 1'b1; host_waddr = a; host_wdata = 32'(d);
        @(posedge clk); #1;
        host_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int v);
        host_raddr = a; #1;
        v = int'(host_rdata);
    endtask

    task automatic strobe();
        @(negedge clk);
        frame_start = 1'b1;
        @(posedge clk); #1;
        frame_start = 1'b0;
    endtask

    task automatic set_hcfg(input int bank, input int mask);
        wr(3'd1, (bank << 4) | mask);
        m_bank = bank; m_mask = mask;
    endtask

    task automatic set_idx(input int i);
        wr(3'd2, i);
        m_idx = (i > DEP - 1) ? DEP - 1 : i;
    endtask

    task automatic data(input int v);
        wr(3'd3, v);
        if (m_ready) begin
            for (int c = 0; c < 3; c++)
                if (m_mask[2 - c]) lut[m_bank][c][m_idx] = v & MSK;
            if (m_idx < DEP - 1) m_idx++;
        end
    endtask

    task automatic pix(input int r, input int g, input int b,
                       output int orr, output int og, output int ob, output int ov);
        @(negedge clk);
        pix_valid = 1'b1; pix_r = PW'(r); pix_g = PW'(g); pix_b = PW'(b);
        @(posedge clk); #1;
        pix_valid = 1'b0;
        ov = int'(out_valid); orr = int'(out_r); og = int'(out_g); ob = int'(out_b);
    endtask

    // Sweep every code; mode selects bypass, RAM bank, or zero output
    task automatic sweep(input string req, input int kind, input int bank);
        int orr, og, ob, ov;
        for (int v = 0; v < NV; v++) begin
            int r = v, g = (v + 5) % NV, b = MSK - v;
            int er, eg, eb;
            pix(r, g, b, orr, og, ob, ov);
            if (kind == 0)      begin er = r; eg = g; eb = b; end
            else if (kind == 1) begin er = lut[bank][0][r]; eg = lut[bank][1][g]; eb = lut[bank][2][b]; end
            else                begin er = 0; eg = 0; eb = 0; end
            check({req, " valid"}, ov, 1);
            check({req, " red"}, orr, er);
            check({req, " green"}, og, eg);
            check({req, " blue"}, ob, eb);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
    end

    initial begin
        int v;
        for (int b = 0; b < 2; b++)
            for (int c = 0; c < 3; c++)
                for (int i = 0; i < DEP; i++) lut[b][c][i] = 0;

        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        rd(3'd0, v); check("R1 ctrl", v, 0);
        rd(3'd1, v); check("R1 hostcfg", v, 7);
        rd(3'd2, v); check("R1 index", v, 0);
        rd(3'd5, v); check("R1 status", v, 0);
        check("R1 out_valid", int'(out_valid), 0);

        // R2 bypass, mode 0 and mode 1
        sweep("R2 bypass mode0", 0, 0);
        wr(3'd0, 1); strobe();
        rd(3'd5, v); check("R2 status mode1", v, 1);
        sweep("R2 bypass mode1", 0, 0);

        // R6/R7 bank A, per-channel curves through single-channel masks
        set_hcfg(0, 4); set_idx(0);
        for (int i = 0; i < DEP; i++) data(i * 3 + 1);
        rd(3'd2, v); check("R7 index saturated after full load", v, DEP - 1);
        data(9); data(11);
        rd(3'd2, v); check("R7 index holds at last entry", v, DEP - 1);
        set_hcfg(0, 2); set_idx(0);
        rd(3'd2, v); check("R7 index restart", v, 0);
        for (int i = 0; i < DEP; i++) data(i * 5 + 2);
        set_hcfg(0, 1); set_idx(0);
        for (int i = 0; i < DEP; i++) data(MSK - i);

        // R6 bank B: all channels, then overwrite green only
        set_hcfg(1, 7); set_idx(0);
        for (int i = 0; i < DEP; i++) data(i * 7 + 3);
        set_hcfg(1, 2); set_idx(0);
        for (int i = 0; i < DEP; i++) data(i ^ 9);

        // R4 change deferred until strobe
        wr(3'd0, 2);
        rd(3'd0, v); check("R4 ctrl pending", v, 2);
        rd(3'd5, v); check("R4 status before strobe", v, 1);
        sweep("R4 still bypass", 0, 0);
        strobe();
        rd(3'd5, v); check("R4 status after strobe", v, 2);
        sweep("R3 bank A lookup", 1, 0);

        wr(3'd0, 2 | 16);
        sweep("R4 bank A kept before strobe", 1, 0);
        strobe();
        rd(3'd5, v); check("R4 status bank B", v, 18);
        sweep("R3 R6 bank B lookup", 1, 1);

        // R5 write inactive bank A while B live
        set_hcfg(0, 7); set_idx(3);
        data(0); data(0);
        sweep("R5 bank B unaffected", 1, 1);
        wr(3'd0, 2); strobe();
        sweep("R5 bank A updated", 1, 0);

        // R7 index clamp
        set_idx(100);
        rd(3'd2, v); check("R7 index clamp", v, DEP - 1);
        set_idx(5);
        rd(3'd2, v); check("R7 index load", v, 5);

        // R8/R9 power
        wr(3'd4, 3); m_ready = 1'b0;
        rd(3'd5, v); check("R8 status off", (v >> 8) & 3, 3);
        rd(3'd4, v); check("R8 force readback", v, 3);
        data(15);
        rd(3'd2, v); check("R9 index unchanged when off", v, 5);
        sweep("R9 zero output when off", 2, 0);
        wr(3'd4, 0);
        rd(3'd5, v); check("R8 status waking", (v >> 8) & 3, 1);
        repeat (WAKE - 1) @(posedge clk);
        #1 rd(3'd5, v); check("R8 status still waking", (v >> 8) & 3, 1);
        @(posedge clk); #1;
        rd(3'd5, v); check("R8 status ready", (v >> 8) & 3, 0);
        m_ready = 1'b1;
        sweep("R9 R3 lookup after wake", 1, 0);
        data(6);
        rd(3'd2, v); check("R7 index steps after wake", v, 6);

        summary();
    end

endmodule